// File: doc/BRIEF.md
# Wait-State Flash Read Buffer

This block serves 32-bit read requests from a system bus out of a flash array that is 64 bits wide and slower than the bus clock. Each fetch reads one aligned 64-bit double-word and returns the 32-bit half that the request addresses. The other half is then served without touching the array. A small configuration field sets how many extra clock cycles each array access is stretched by. With that field at zero, the block completes one request on every clock cycle.

The registered output of the array doubles as the one-entry double-word buffer, and a tag register beside it records which double-word it holds. A bus master raises the request with an address and holds both until the ready output goes high for one cycle. During that cycle the data output carries the word, and the master may present its next request. Any write to the array, and any change of the wait-state field, makes the buffered copy unusable.

Top module: `flash_rd_buffer`

## Requirements
- R1: After reset, and after a reset applied during operation, `rd_ready` is low, and the first request at any address is served as a miss.
- R2: With `ws_cfg` equal to 0, a request accepted at a clock edge makes `rd_ready` high in the cycle right after that edge, whether or not the double-word is buffered.
- R3: With `ws_cfg` equal to N (N above 0), a request that misses the buffer keeps `rd_ready` low for N cycles after the accepting edge and raises it in cycle N+1.
- R4: A request that hits the buffer makes `rd_ready` high in the cycle after the accepting edge, for every value of `ws_cfg`.
- R5: `rd_data` equals bits [63:32] of array double-word `rd_addr[IDX_W+2:3]` when `rd_addr[2]` is 1, and bits [31:0] of that double-word when `rd_addr[2]` is 0.
- R6: Once a double-word has been fetched, a request for either of its two words hits the buffer.
- R7: A request whose address bits [31:3] differ from those of the buffered double-word misses, including when its array index bits are equal.
- R8: A write through `arr_we` changes the array double-word at `arr_widx`, and the next request after the write misses, at any address.
- R9: A change of `ws_cfg` makes the next request miss.
- R10: With `ws_cfg` equal to 0, a master that presents a new address in every ready cycle receives a correct word on every clock cycle.
- R11: When no request is presented to an idle block, `rd_ready` stays low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_cfg | input | WS_W | Extra cycles per array access; 0 selects single-cycle operation |
| rd_req | input | 1 | Read request, held until `rd_ready` is high |
| rd_addr | input | ADDR_W | Byte address of the 32-bit word, held with `rd_req` |
| rd_ready | output | 1 | One-cycle pulse marking the cycle in which `rd_data` is valid |
| rd_data | output | 32 | Returned 32-bit word |
| arr_we | input | 1 | Write strobe for one array double-word |
| arr_widx | input | IDX_W | Double-word index of the write |
| arr_wdata | input | 64 | Double-word written to the array |

## Verification
The bench counts the cycles from acceptance to `rd_ready` for every request, so a design that fetched the companion word again, or skipped the stall on a miss, shows the wrong latency even when the data is right. Addresses that share an array index but differ in the upper bits catch a tag compare that covers too few bits: such a design would return a hit with the wrong double-word. Writes and wait-state changes followed by reads of a word that was buffered before catch a design that keeps a stale valid bit. Single-cycle streaming with misses and hits interleaved catches a design that adds a bubble in its zero-wait path or selects the wrong half.

// File: rtl/flash_rd_buffer_pkg.sv
package flash_rd_buffer_pkg;

  localparam int DWORD_W = 64;
  localparam int WORD_W  = 32;

  typedef enum logic {
    RB_IDLE = 1'b0,
    RB_WAIT = 1'b1
  } rb_state_e;

endpackage

// File: rtl/frb_dword_array.sv
module frb_dword_array #(
  parameter int DEPTH = 64,
  parameter int DW    = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[widx] <= wdata;
    end
  end

  // Registered read port; the register holds its value between reads and
  // serves as the double-word buffer of the block.
  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[ridx];
    end
  end

endmodule

// File: rtl/frb_ws_timer.sv
module frb_ws_timer #(
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [WS_W-1:0] ws,
  input  logic            run,
  output logic            done
);

  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= ws;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == {{(WS_W-1){1'b0}}, 1'b1});

  AST_RUN_HAS_COUNT: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q != '0)); // R3

endmodule

// File: rtl/frb_tag_reg.sv
module frb_tag_reg #(
  parameter int TAG_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             load,
  input  logic             fill,
  input  logic [TAG_W-1:0] tag_in,
  output logic             hit
);

  logic [TAG_W-1:0] tag_q;
  logic             valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
    end else if (load) begin
      tag_q <= tag_in;
    end
  end

  // Flush wins over a fill in the same cycle; a fill in the load cycle
  // (single-cycle access) leaves the entry valid.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (fill) begin
      valid_q <= 1'b1;
    end else if (load) begin
      valid_q <= 1'b0;
    end
  end

  assign hit = valid_q && (tag_q == tag_in) && !flush;

  AST_FLUSH_KILLS_HIT: assert property (@(posedge clk) disable iff (rst)
    flush |=> !hit); // R8

endmodule

// File: rtl/flash_rd_buffer.sv
module flash_rd_buffer
  import flash_rd_buffer_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WS_W      = 2,
  parameter int ARR_DEPTH = 64,
  localparam int IDX_W    = $clog2(ARR_DEPTH),
  localparam int TAG_W    = ADDR_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WS_W-1:0]   ws_cfg,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  input  logic              arr_we,
  input  logic [IDX_W-1:0]  arr_widx,
  input  logic [DWORD_W-1:0] arr_wdata
);

  rb_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              half_q;
  logic              ready_q;
  logic [WS_W-1:0]   ws_q;
  logic [DWORD_W-1:0] dw_q;

  logic              accept;
  logic              hit;
  logic              ws_zero;
  logic              ws_chg;
  logic              flush;
  logic              start_wait;
  logic              wait_done;
  logic              arr_re;
  logic [IDX_W-1:0]  arr_ridx;
  logic [IDX_W-1:0]  req_idx;
  logic              unused_addr_lsb;

  assign unused_addr_lsb = ^rd_addr[1:0];

  assign req_idx    = rd_addr[IDX_W+2:3];
  assign ws_zero    = (ws_cfg == '0);
  assign ws_chg     = (ws_cfg != ws_q);
  assign flush      = arr_we || ws_chg;
  assign accept     = (state_q == RB_IDLE) && rd_req;
  assign start_wait = accept && !hit && !ws_zero;
  assign arr_re     = (accept && !hit && ws_zero) ||
                      ((state_q == RB_WAIT) && wait_done);
  assign arr_ridx   = (state_q == RB_IDLE) ? req_idx : idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q <= ws_cfg;
    end else begin
      ws_q <= ws_cfg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RB_IDLE;
      ready_q <= 1'b0;
      half_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      ready_q <= 1'b0;
      unique case (state_q)
        RB_IDLE: begin
          if (accept) begin
            half_q <= rd_addr[2];
            idx_q  <= req_idx;
            if (hit || ws_zero) begin
              ready_q <= 1'b1;
            end else begin
              state_q <= RB_WAIT;
            end
          end
        end
        RB_WAIT: begin
          if (wait_done) begin
            ready_q <= 1'b1;
            state_q <= RB_IDLE;
          end
        end
        default: state_q <= RB_IDLE;
      endcase
    end
  end

  frb_dword_array #(
    .DEPTH (ARR_DEPTH),
    .DW    (DWORD_W)
  ) u_array (
    .clk   (clk),
    .we    (arr_we),
    .widx  (arr_widx),
    .wdata (arr_wdata),
    .re    (arr_re),
    .ridx  (arr_ridx),
    .rdata (dw_q)
  );

  frb_ws_timer #(
    .WS_W (WS_W)
  ) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (start_wait),
    .ws   (ws_cfg),
    .run  (state_q == RB_WAIT),
    .done (wait_done)
  );

  frb_tag_reg #(
    .TAG_W (TAG_W)
  ) u_tag (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .load   (accept && !hit),
    .fill   (arr_re),
    .tag_in (rd_addr[ADDR_W-1:3]),
    .hit    (hit)
  );

  generate
    if (WORD_W * 2 == DWORD_W) begin : g_half_sel
      assign rd_data = half_q ? dw_q[DWORD_W-1:WORD_W] : dw_q[WORD_W-1:0];
    end
  endgenerate

  assign rd_ready = ready_q;

  AST_FAST_PATH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (accept && (hit || ws_zero)) |=> rd_ready); // R4
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (rst)
    start_wait |=> !rd_ready); // R3
  AST_WAIT_KEEPS_READY_LOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == RB_WAIT) |-> !rd_ready); // R3
  AST_IDLE_NO_REQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((state_q == RB_IDLE) && !rd_req) |=> !rd_ready); // R11
  AST_WS_CHANGE_MISSES: assert property (@(posedge clk) disable iff (rst)
    (ws_chg && accept) |-> !hit); // R9

endmodule

// File: tb/sim_flash_rd_buffer.sv
`timescale 1ns/1ps
module sim_flash_rd_buffer;

  localparam int DEPTH = 64;
  localparam int IW    = 6;

  typedef struct packed {
    logic [1:0]  ws;
    logic [31:0] addr;
    logic [3:0]  lat;
  } vec_t;

  // ws, address, expected cycles from accepting edge to ready
  localparam vec_t VECS [12] = '{
    '{2'd0, 32'h0000_0000, 4'd1},  // R2 miss, single-cycle
    '{2'd0, 32'h0000_0004, 4'd1},  // R6 companion hit
    '{2'd2, 32'h0000_0010, 4'd3},  // R9 ws change, R3 miss
    '{2'd2, 32'h0000_0014, 4'd1},  // R4 hit upper half
    '{2'd2, 32'h0000_0010, 4'd1},  // R4 hit lower half
    '{2'd2, 32'h0000_0018, 4'd3},  // R3 other pair
    '{2'd2, 32'h0000_0210, 4'd3},  // R7 alias of index 2
    '{2'd2, 32'h0000_0214, 4'd1},  // R6 hit after alias
    '{2'd3, 32'h0000_0214, 4'd4},  // R9 ws change misses
    '{2'd1, 32'h0000_03F8, 4'd2},  // R3 last index
    '{2'd1, 32'h0000_03FC, 4'd1},  // R5 upper half
    '{2'd0, 32'h0000_0100, 4'd1}   // R2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ws_cfg = 2'd0;
  logic        rd_req = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        rd_ready;
  logic [31:0] rd_data;
  logic        arr_we = 1'b0;
  logic [IW-1:0] arr_widx = '0;
  logic [63:0] arr_wdata = '0;

  logic [63:0] shadow [DEPTH];
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  flash_rd_buffer u0 (
    .clk       (clk),
    .rst       (rst),
    .ws_cfg    (ws_cfg),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .arr_we    (arr_we),
    .arr_widx  (arr_widx),
    .arr_wdata (arr_wdata)
  );

  function automatic logic [63:0] pat(input int i, input bit alt);
    logic [63:0] v;
    v = {32'hC0DE_0000 + 32'(i), 32'h5A00_0000 + 32'(i * 3)};
    return alt ? ~v : v;
  endfunction

  function automatic logic [31:0] expect_word(input logic [31:0] a);
    logic [63:0] d;
    d = shadow[a[IW+2:3]];
    return a[2] ? d[63:32] : d[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int i, input logic [63:0] d);
    @(negedge clk);
    arr_we = 1'b1; arr_widx = IW'(i); arr_wdata = d;
    @(posedge clk); #1;
    arr_we = 1'b0;
    shadow[i] = d;
  endtask

  task automatic set_ws(input logic [1:0] v);
    @(negedge clk);
    ws_cfg = v;
    @(posedge clk); #1;
  endtask

  task automatic do_read(input logic [31:0] a, output int lat,
                         output logic [31:0] d);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; lat = 0;
    do begin
      @(posedge clk); #1;
      lat++;
    end while (!rd_ready && lat < 20);
    d = rd_data;
    rd_req = 1'b0;
  endtask

  task automatic read_chk(input logic [31:0] a, input int exp_lat,
                          input string req);
    int lat;
    logic [31:0] d;
    do_read(a, lat, d);
    chk(lat == exp_lat, req, 32'(lat), 32'(exp_lat));
    chk(d == expect_word(a), req, d, expect_word(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rd_ready == 1'b0, "R1 reset ready", 32'(rd_ready), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < DEPTH; i++) wr(i, pat(i, 1'b0));

    // Table walk
    for (int k = 0; k < 12; k++) begin
      if (ws_cfg != VECS[k].ws) set_ws(VECS[k].ws);
      read_chk(VECS[k].addr, int'(VECS[k].lat), $sformatf("R3/R4/R5 vec%0d", k));
    end

    // R11: idle with no request
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(rd_ready == 1'b0, "R11 no request", 32'(rd_ready), 32'd0);
    end

    // R8: write to another index still invalidates, new data visible
    set_ws(2'd1);
    read_chk(32'h0000_0100, 2, "R8 refill");
    read_chk(32'h0000_0104, 1, "R6 companion");
    wr(5, pat(5, 1'b1));
    read_chk(32'h0000_0104, 2, "R8 write invalidates");
    wr(32, pat(32, 1'b1));
    read_chk(32'h0000_0100, 2, "R8 new data");

    // R10: single-cycle streaming, new address in every ready cycle
    set_ws(2'd0);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = 32'h0000_0040;
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a;
      a = 32'h0000_0040 + 32'(4 * i);
      @(posedge clk); #1;
      chk(rd_ready == 1'b1, "R10 ready every cycle", 32'(rd_ready), 32'd1);
      chk(rd_data == expect_word(a), "R10 stream data", rd_data, expect_word(a));
      rd_addr = a + 32'd4;
    end
    rd_req = 1'b0;

    // R1: reset during operation drops the buffer
    set_ws(2'd1);
    read_chk(32'h0000_0080, 2, "R3 before reset");
    read_chk(32'h0000_0084, 1, "R4 before reset");
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk(rd_ready == 1'b0, "R1 reset mid-run", 32'(rd_ready), 32'd0);
    @(negedge clk); rst = 1'b0;
    read_chk(32'h0000_0084, 2, "R1 miss after reset");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule